// File: doc/BRIEF.md
# USB Charger Identification Mode Controller

This block is the digital control for a USB host port that can keep charging an attached device while the host is asleep. A two-bit mode input selects one of four line connections for the D+/D- pair:
- automatic detection,
- a forced short between the two data lines,
- a forced resistor-bias network,
- a direct path to the host transceiver.

In automatic mode, a two-state loop watches debounced comparator levels on D-. It starts with the bias network connected. It moves to the short when D- sags below a high threshold. It returns to the bias network when D- sinks below a low threshold.

A third comparator reports whether external bias resistors are fitted. From it, the block decides whether the internal divider's pull-up supply may be switched on. The supply is enabled only while the bias network is connected and no external resistors are detected.

All asynchronous inputs pass through two-flop synchronizers. Each comparator level must hold for a parameterized number of 1 MHz ticks before it is acted on. The outputs are registered, mutually exclusive switch enables.

Top module: `chgid_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, `pass_en`, `short_en`, `res_en`, `int_bias_pwr_en` and `ext_bias_sel` are all 0.
- R2: With `mode_pins` = 2'b11, only `pass_en` is asserted.
- R3: With `mode_pins` = 2'b01, only `short_en` is asserted and the internal bias supply is off.
- R4: With `mode_pins` = 2'b10, only `res_en` is asserted.
- R5: After the first cycle out of reset, exactly one of `pass_en`, `short_en`, `res_en` is asserted in every cycle.
- R6: On entry into automatic mode (`mode_pins` = 2'b00), the bias network is selected (`res_en`).
- R7: In automatic mode with the bias network selected, the selection holds while the debounced `dm_above_hi` is 1. It changes to the short once the debounced `dm_above_hi` is 0.
- R8: In the shorted state, the short holds while the debounced `dm_above_lo` is 1. It returns to the bias network once the debounced `dm_above_lo` is 0. On that return, the high-threshold level is re-armed as 1, so a new full debounce of a low D- is needed before the block shorts again.
- R9: A comparator level is acted on only after it has held for DEBOUNCE_CYCLES ticks of `tick_1us` (default 100). Any shorter pulse causes no change at the outputs.
- R10: `int_bias_pwr_en` is 1 exactly when `res_en` is 1 and `ext_bias_sel` is 0. `ext_bias_sel` follows the debounced `bias_ext_det`.
- R11: Leaving automatic mode and re-entering it restarts detection with the bias network selected.
- R12: A mode change on `mode_pins` shows at the outputs on the third rising clock edge after it. Two edges are spent in the synchronizer and one in the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1us | input | 1 | One-cycle debounce time-base strobe, nominally 1 MHz |
| mode_pins | input | 2 | Asynchronous mode select: 00 auto, 01 short, 10 bias, 11 pass |
| dm_above_hi | input | 1 | Asynchronous comparator: D- at or above the high threshold |
| dm_above_lo | input | 1 | Asynchronous comparator: D- above the low threshold |
| bias_ext_det | input | 1 | Asynchronous comparator: external bias resistors detected |
| pass_en | output | 1 | Connect D+/D- to the transceiver |
| short_en | output | 1 | Short D+ to D- |
| res_en | output | 1 | Connect the resistor-bias network |
| int_bias_pwr_en | output | 1 | Enable the internal divider pull-up supply |
| ext_bias_sel | output | 1 | External bias resistors in use |

## Verification
The supply gate draws on two independent debounce paths: the D- high-threshold path, which drives the detection loop, and the external-bias path. The bench drops `dm_above_hi` and raises `bias_ext_det` on the same clock. Both paths then mature on the same edge, so the move to the short and the switch to external bias land together.

This collision is judged in two ways. At every cycle through the transition, the bench checks that `int_bias_pwr_en` is never high unless the bias network is connected and external resistors are not selected. At the end, the outputs must show the short with external bias and the supply off.

// File: rtl/chgid_pkg.sv
// Shared types for the charger identification mode controller.
// Assumes the mode pin encoding is fixed by the board connection.
package chgid_pkg;

    typedef enum logic [1:0] {
        MODE_AUTO  = 2'b00,
        MODE_SHORT = 2'b01,
        MODE_BIAS  = 2'b10,
        MODE_PASS  = 2'b11
    } mode_e;

    typedef enum logic {
        DET_BIAS  = 1'b0,
        DET_SHORT = 1'b1
    } det_state_e;

    typedef struct packed {
        logic pass_on;
        logic short_on;
        logic bias_on;
    } path_t;

    localparam int NUM_CMP = 3;
    localparam int CMP_HI  = 0;
    localparam int CMP_LO  = 1;
    localparam int CMP_EXT = 2;

endpackage

// File: rtl/chgid_sync.sv
// Multi-stage synchronizer for asynchronous level inputs.
// Assumes the inputs are quasi-static levels; no pulse capture is intended.
module chgid_sync #(
    parameter int           WIDTH   = 1,
    parameter int           STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stg [STAGES];

    // Shift the raw levels through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d_async;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/chgid_debounce.sv
// Tick-based debouncer: the output takes a new level only after the
// synchronized input has held it for CNT_MAX ticks. Any change restarts
// the count. A rearm pulse reloads the output with INIT so that a fresh
// full debounce is needed. Assumes the input is already synchronized.
module chgid_debounce #(
    parameter int   CNT_MAX = 100,
    parameter logic INIT    = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rearm,
    input  logic raw,
    output logic level
);

    localparam int CW = $clog2(CNT_MAX + 1);

    logic          cand;
    logic [CW-1:0] cnt;

    // Track the candidate level, count stable ticks, commit at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || rearm) begin
            cand  <= INIT;
            level <= INIT;
            cnt   <= '0;
        end else if (raw != cand) begin
            cand <= raw;
            cnt  <= '0;
        end else if (cand == level) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt == CW'(CNT_MAX - 1)) begin
                level <= cand;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R9: a level that has just moved away from the candidate cannot commit.
    p_no_early_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (raw != cand && !rearm) |=> $stable(level));

endmodule

// File: rtl/chgid_det_fsm.sv
// Two-state charger detection loop used in automatic mode.
// Assumes debounced comparator levels. Outside automatic mode, the loop
// is held in the bias state so that re-entry always starts there.
module chgid_det_fsm
    import chgid_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       auto_mode,
    input  logic       dm_hi_ok,
    input  logic       dm_lo_ok,
    output det_state_e state,
    output logic       rearm_hi
);

    det_state_e state_d;

    // Next-state decision from the current state and the threshold levels.
    always_comb begin
        state_d = state;
        if (!auto_mode) begin
            state_d = DET_BIAS;
        end else begin
            case (state)
                DET_BIAS:  if (!dm_hi_ok) state_d = DET_SHORT;
                DET_SHORT: if (!dm_lo_ok) state_d = DET_BIAS;
                default:   state_d = DET_BIAS;
            endcase
        end
    end

    assign rearm_hi = auto_mode && (state == DET_SHORT) && !dm_lo_ok;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= DET_BIAS;
        else        state <= state_d;
    end

    p_hold_bias_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && state == DET_BIAS && dm_hi_ok) |=> state == DET_BIAS);
    p_hold_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && state == DET_SHORT && dm_lo_ok) |=> state == DET_SHORT);
    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_mode |=> state == DET_BIAS);

endmodule

// File: rtl/chgid_mode_ctrl.sv
// Charger identification mode controller (top).
// Synchronizes the mode pins and comparators, debounces the comparators,
// runs the detection loop and drives registered one-hot switch enables
// plus the internal bias supply gate. Assumes tick_1us is a one-cycle strobe.
module chgid_mode_ctrl
    import chgid_pkg::*;
#(
    parameter int DEBOUNCE_CYCLES = 100,
    parameter int SYNC_STAGES     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1us,
    input  logic [1:0] mode_pins,
    input  logic       dm_above_hi,
    input  logic       dm_above_lo,
    input  logic       bias_ext_det,
    output logic       pass_en,
    output logic       short_en,
    output logic       res_en,
    output logic       int_bias_pwr_en,
    output logic       ext_bias_sel
);

    localparam logic [NUM_CMP-1:0] CMP_INIT = 3'b011;

    logic [1:0]         mode_s;
    logic [NUM_CMP-1:0] cmp_raw, cmp_s, cmp_db, cmp_rearm;
    det_state_e         det_state;
    logic               rearm_hi;
    logic               auto_mode;
    path_t              path_d, path_q;
    logic               sup_d, sup_q, ext_q, primed;

    assign cmp_raw = {bias_ext_det, dm_above_lo, dm_above_hi};

    chgid_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_mode_sync (
        .clk(clk), .rst_n(rst_n), .d_async(mode_pins), .q_sync(mode_s));

    chgid_sync #(.WIDTH(NUM_CMP), .STAGES(SYNC_STAGES), .RST_VAL(CMP_INIT)) u_cmp_sync (
        .clk(clk), .rst_n(rst_n), .d_async(cmp_raw), .q_sync(cmp_s));

    assign cmp_rearm = {1'b0, 1'b0, rearm_hi};

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_deb
        chgid_debounce #(.CNT_MAX(DEBOUNCE_CYCLES), .INIT(CMP_INIT[g])) u_deb (
            .clk(clk), .rst_n(rst_n), .tick(tick_1us), .rearm(cmp_rearm[g]),
            .raw(cmp_s[g]), .level(cmp_db[g]));
    end

    assign auto_mode = (mode_e'(mode_s) == MODE_AUTO);

    chgid_det_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode),
        .dm_hi_ok(cmp_db[CMP_HI]), .dm_lo_ok(cmp_db[CMP_LO]),
        .state(det_state), .rearm_hi(rearm_hi));

    // Decode the synchronized mode and detection state into one switch path.
    always_comb begin
        path_d = '0;
        case (mode_e'(mode_s))
            MODE_PASS:  path_d.pass_on  = 1'b1;
            MODE_SHORT: path_d.short_on = 1'b1;
            MODE_BIAS:  path_d.bias_on  = 1'b1;
            default: begin
                if (det_state == DET_SHORT) path_d.short_on = 1'b1;
                else                        path_d.bias_on  = 1'b1;
            end
        endcase
        sup_d = path_d.bias_on && !cmp_db[CMP_EXT];
    end

    // Output register; everything off during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            path_q <= '0;
            sup_q  <= 1'b0;
            ext_q  <= 1'b0;
            primed <= 1'b0;
        end else begin
            path_q <= path_d;
            sup_q  <= sup_d;
            ext_q  <= cmp_db[CMP_EXT];
            primed <= 1'b1;
        end
    end

    assign pass_en         = path_q.pass_on;
    assign short_en        = path_q.short_on;
    assign res_en          = path_q.bias_on;
    assign int_bias_pwr_en = sup_q;
    assign ext_bias_sel    = ext_q;

    p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pass_en, short_en, res_en}));
    p_one_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> $countones({pass_en, short_en, res_en}) == 1);
    p_sup_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int_bias_pwr_en |-> (res_en && !ext_bias_sel));
    p_sup_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && res_en && !ext_bias_sel) |-> int_bias_pwr_en);
    p_pass_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s == 2'b11) |=> pass_en);
    p_short_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s == 2'b01) |=> (short_en && !int_bias_pwr_en));

endmodule

// File: tb/chgid_mode_ctrl_tb.sv
module chgid_mode_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEB        = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1us = 1'b0;
    logic [1:0] mode_pins = 2'b11;
    logic       dm_above_hi = 1'b1;
    logic       dm_above_lo = 1'b1;
    logic       bias_ext_det = 1'b0;
    logic       pass_en, short_en, res_en, int_bias_pwr_en, ext_bias_sel;

    int n_chk = 0;
    int n_fail = 0;

    chgid_mode_ctrl #(.DEBOUNCE_CYCLES(DEB)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .mode_pins(mode_pins),
        .dm_above_hi(dm_above_hi), .dm_above_lo(dm_above_lo),
        .bias_ext_det(bias_ext_det), .pass_en(pass_en), .short_en(short_en),
        .res_en(res_en), .int_bias_pwr_en(int_bias_pwr_en),
        .ext_bias_sel(ext_bias_sel));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Tick strobe every second clock, changed away from the rising edge.
    always @(negedge clk) tick_1us <= ~tick_1us;

    task automatic wait_ticks(input int n);
        repeat (2 * n) @(negedge clk);
    endtask

    // Expected order: pass, short, res, supply, ext_sel.
    task automatic chk(input string req, input logic [4:0] exp);
        logic [4:0] got;
        got = {pass_en, short_en, res_en, int_bias_pwr_en, ext_bias_sel};
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode_pins = m;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (4) @(negedge clk);
        chk("R1 reset", 5'b00000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 R12 pass mode", 5'b10000);
    endtask

    task automatic t_fixed_modes;
        set_mode(2'b01);
        chk("R3 R12 forced short", 5'b01000);
        set_mode(2'b10);
        chk("R4 R10 forced bias internal", 5'b00110);
        bias_ext_det = 1'b1;
        wait_ticks(DEB + 10);
        chk("R10 external bias", 5'b00101);
        bias_ext_det = 1'b0;
        wait_ticks(DEB + 10);
        chk("R10 back to internal", 5'b00110);
    endtask

    task automatic t_auto_cycle;
        set_mode(2'b00);
        chk("R6 auto entry", 5'b00110);
        wait_ticks(2 * DEB);
        chk("R7 hold bias", 5'b00110);
        dm_above_hi = 1'b0;
        wait_ticks(DEB - 10);
        chk("R9 not yet debounced", 5'b00110);
        wait_ticks(20);
        chk("R7 enter short", 5'b01000);
        wait_ticks(2 * DEB);
        chk("R8 hold short", 5'b01000);
        dm_above_lo = 1'b0;
        wait_ticks(DEB + 10);
        chk("R8 back to bias", 5'b00110);
        dm_above_hi = 1'b1;
        dm_above_lo = 1'b1;
        wait_ticks(3 * DEB);
        chk("R8 rearm keeps bias", 5'b00110);
    endtask

    task automatic t_glitch;
        dm_above_hi = 1'b0;
        wait_ticks(DEB / 2);
        dm_above_hi = 1'b1;
        wait_ticks(DEB + 50);
        chk("R9 high-threshold glitch", 5'b00110);
        dm_above_hi = 1'b0;
        wait_ticks(DEB + 10);
        chk("R7 short again", 5'b01000);
        dm_above_lo = 1'b0;
        wait_ticks(DEB / 2);
        dm_above_lo = 1'b1;
        wait_ticks(DEB + 50);
        chk("R9 low-threshold glitch", 5'b01000);
    endtask

    task automatic t_leave_auto;
        set_mode(2'b11);
        chk("R11 leave auto", 5'b10000);
        dm_above_hi = 1'b1;
        wait_ticks(DEB + 10);
        set_mode(2'b00);
        chk("R11 re-enter in bias", 5'b00110);
    endtask

    task automatic t_same_cycle;
        int viol;
        viol = 0;
        dm_above_hi = 1'b0;
        bias_ext_det = 1'b1;
        for (int i = 0; i < 2 * (DEB + 10); i++) begin
            @(negedge clk);
            if (int_bias_pwr_en && !(res_en && !ext_bias_sel)) viol++;
        end
        n_chk++;
        if (viol != 0) begin
            n_fail++;
            $display("FAIL R10 supply gate: got %0d bad cycles expected 0", viol);
        end
        chk("R7 R10 short with external bias", 5'b01001);
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        t_reset();
        t_fixed_modes();
        t_auto_cycle();
        t_glitch();
        t_leave_auto();
        t_same_cycle();
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

endmodule